// File: doc/BRIEF.md
# Store Queue with Byte-Granular Load Forwarding

The block holds stores that are in flight, in program order, in a circular queue. A store gets an entry at the tail. It carries a sequence tag, a size, its data and either a resolved address or a flag saying the address is not yet known. A store whose address was unknown is resolved later through an update port. The update names the entry index that the queue reported when the store was allocated. Stores leave from the head, one per commit request, and only once their address is known.

When a load issues, every entry is searched in parallel. Each byte of the load is built on its own. Among the valid stores that are older than the load (by sequence tag) and whose bytes cover that address, the youngest one supplies the byte. The result returns one cycle later with a per-byte hit mask. Bytes with a clear hit bit must be merged from memory by the caller. An unknown flag is also returned, raised when any older store still lacks an address. That flag is the only violation hint the block gives. It does not search loads.

Top module: `store_fwd_queue`

## Requirements
- R1: After reset the queue is empty: `full_o` is 0, `cm_rdy_o` is 0, `st_alloc_idx_o` is 0, and `ld_valid_o`, `ld_hit_o`, `ld_data_o` and `ld_unknown_o` are 0.
- R2: An allocation takes the entry at the tail. `st_alloc_idx_o` shows that index before the edge, and indices advance by one modulo DEPTH. After DEPTH stores are held, `full_o` is 1, and an allocation while full is dropped and never reaches commit.
- R3: `cm_rdy_o` is 1 when the head entry is valid and its address is known. In that case `cm_addr_o`, `cm_size_o` and `cm_data_o` show the head store, and `cm_i` retires it. A `cm_i` while `cm_rdy_o` is 0 changes nothing.
- R4: Size code 0 means 1 byte, 1 means 2 bytes, 2 and 3 mean 4 bytes. Data is low-justified and little-endian: store data bits [8k+7:8k] belong to address start+k. Addresses need no alignment and wrap modulo 2^AW.
- R5: A load presented with `ld_valid_i` at an edge returns its result on the outputs after that edge, with `ld_valid_o` set. The result reflects the queue contents before that edge, so a store allocated at the same edge is not seen.
- R6: For each load byte, the youngest covering store with a known address among the stores older than the load supplies the byte, and the byte's `ld_hit_o` bit is set.
- R7: A store is older than a load when, with the tag's top bit as a wrap bit, the wrap bits are equal and the store's lower bits are smaller, or the wrap bits differ and the store's lower bits are larger. Stores that are not older have no effect on the load.
- R8: A load byte that no older store covers has its hit bit 0 and reads 0. Hit bits at or above the load size are 0.
- R9: With `ld_signed_i` set, bytes above the load size are copies of bit 7 of the load's top byte when that byte is forwarded. Otherwise they are 0.
- R10: `ld_unknown_o` is 1 when any valid store older than the load has no known address, and it does not stop the forwarding of known bytes. Younger unresolved stores do not raise it.
- R11: `st_upd_i` writes `st_upd_addr_i` into entry `st_upd_idx_i` and marks its address known. Loads issued afterwards forward from that store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_alloc_i | input | 1 | Allocate a store at the tail |
| st_alloc_seq_i | input | SEQ_W | Sequence tag of the store |
| st_alloc_known_i | input | 1 | Store address is already resolved |
| st_alloc_addr_i | input | AW | Start address (used when known) |
| st_alloc_size_i | input | 2 | Size code |
| st_alloc_data_i | input | 32 | Store data, low-justified |
| st_alloc_idx_o | output | log2(DEPTH) | Entry index the next allocation takes |
| full_o | output | 1 | No free entry |
| st_upd_i | input | 1 | Resolve the address of an entry |
| st_upd_idx_i | input | log2(DEPTH) | Entry to resolve |
| st_upd_addr_i | input | AW | Resolved start address |
| ld_valid_i | input | 1 | Load lookup request |
| ld_seq_i | input | SEQ_W | Sequence tag of the load |
| ld_addr_i | input | AW | Load start address |
| ld_size_i | input | 2 | Load size code |
| ld_signed_i | input | 1 | Sign-extend the result |
| ld_valid_o | output | 1 | Lookup result valid |
| ld_data_o | output | 32 | Forwarded and extended data |
| ld_hit_o | output | 4 | Per-byte forwarded flags |
| ld_unknown_o | output | 1 | An older store has an unresolved address |
| cm_i | input | 1 | Retire the head store |
| cm_rdy_o | output | 1 | Head store can retire |
| cm_addr_o | output | AW | Head store address |
| cm_size_o | output | 2 | Head store size code |
| cm_data_o | output | 32 | Head store data |

## Verification
The bench places unaligned stores of mixed sizes that overlap partly, then issues loads whose bytes come from different stores. A design that chose the oldest covering store, or that did one match per load instead of per byte, would return stale bytes. Loads whose tags fall between store tags show whether younger stores leak in, including across the tag wrap. A design that compared tags without the wrap bit would forward there or lose a hit. The bench also covers several other cases. It checks sign extension when the top byte is missing, and expects an error there to show as a spurious fill. It checks the unknown flag before and after resolution. It checks a commit refused at an unresolved head, which an eager design would retire. It checks a dropped allocation while full, which would show up as a seventeenth commit. Last, a load in the same cycle as an allocation must not see that store.

// File: rtl/stq_pkg.sv
package stq_pkg;

   localparam int LANES = 4;

   // size code to byte count: 0 -> 1, 1 -> 2, 2/3 -> 4
   function automatic logic [2:0] size_bytes(input logic [1:0] code);
      case (code)
         2'd0:    size_bytes = 3'd1;
         2'd1:    size_bytes = 3'd2;
         default: size_bytes = 3'd4;
      endcase
   endfunction

   // tag a precedes tag b; top bit of a w-bit tag is the wrap bit
   function automatic logic seq_older(input logic [31:0] a, input logic [31:0] b, input int w);
      logic [31:0] m;
      logic        wa, wb;
      m  = (32'd1 << (w - 1)) - 32'd1;
      wa = a[w-1];
      wb = b[w-1];
      if (wa == wb) seq_older = (a & m) < (b & m);
      else          seq_older = (a & m) > (b & m);
   endfunction

endpackage

// File: rtl/stq_ptrs.sv
module stq_ptrs #(
   parameter int DEPTH = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     push_i,
   input  logic                     pop_i,
   output logic [$clog2(DEPTH)-1:0] head_o,
   output logic [$clog2(DEPTH)-1:0] tail_o,
   output logic                     full_o,
   output logic                     empty_o
);
   localparam int IDX_W = $clog2(DEPTH);

   logic [IDX_W:0] head_q, tail_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head_q <= '0;
         tail_q <= '0;
      end else begin
         if (push_i) tail_q <= tail_q + 1'b1;
         if (pop_i)  head_q <= head_q + 1'b1;
      end
   end

   assign head_o  = head_q[IDX_W-1:0];
   assign tail_o  = tail_q[IDX_W-1:0];
   assign empty_o = (head_q == tail_q);
   assign full_o  = (head_q[IDX_W] != tail_q[IDX_W]) &&
                    (head_q[IDX_W-1:0] == tail_q[IDX_W-1:0]);
endmodule

// File: rtl/stq_lane.sv
module stq_lane
   import stq_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int AW    = 32,
   parameter int SEQ_W = 6,
   parameter int LANE  = 0
) (
   input  logic [$clog2(DEPTH)-1:0]  head_i,
   input  logic [DEPTH-1:0]          vld_i,
   input  logic [DEPTH-1:0]          known_i,
   input  logic [DEPTH-1:0][AW-1:0]  addr_i,
   input  logic [DEPTH-1:0][1:0]     size_i,
   input  logic [DEPTH-1:0][31:0]    data_i,
   input  logic [DEPTH-1:0][SEQ_W-1:0] seq_i,
   input  logic [AW-1:0]             ld_addr_i,
   input  logic [SEQ_W-1:0]          ld_seq_i,
   input  logic [1:0]                ld_size_i,
   output logic                      hit_o,
   output logic [7:0]                byte_o
);
   localparam int IDX_W = $clog2(DEPTH);

   logic [AW-1:0]    lane_addr;
   logic             lane_on;
   logic [IDX_W-1:0] pos;
   logic [AW-1:0]    off;

   assign lane_addr = ld_addr_i + AW'(LANE);
   assign lane_on   = size_bytes(ld_size_i) > 3'(LANE);

   // walk from oldest to youngest; a later match overrides an earlier one
   always_comb begin
      hit_o  = 1'b0;
      byte_o = 8'h00;
      pos    = '0;
      off    = '0;
      for (int k = 0; k < DEPTH; k++) begin
         pos = head_i + IDX_W'(k);
         off = lane_addr - addr_i[pos];
         if (lane_on && vld_i[pos] && known_i[pos] &&
             seq_older(32'(seq_i[pos]), 32'(ld_seq_i), SEQ_W) &&
             (off < AW'(size_bytes(size_i[pos])))) begin
            hit_o  = 1'b1;
            byte_o = data_i[pos][8*off[1:0] +: 8];
         end
      end
   end
endmodule

// File: rtl/stq_extend.sv
module stq_extend
   import stq_pkg::*;
(
   input  logic [LANES-1:0][7:0] bytes_i,
   input  logic [LANES-1:0]      hit_i,
   input  logic [1:0]            size_i,
   input  logic                  sgn_i,
   output logic [31:0]           data_o
);
   logic [2:0] nb;
   logic [1:0] top;
   logic       fill;

   always_comb begin
      nb   = size_bytes(size_i);
      top  = 2'(nb - 3'd1);
      fill = sgn_i && hit_i[top] && bytes_i[top][7];
      for (int b = 0; b < LANES; b++) begin
         data_o[8*b +: 8] = (3'(b) < nb) ? bytes_i[b] : {8{fill}};
      end
   end
endmodule

// File: rtl/store_fwd_queue.sv
module store_fwd_queue
   import stq_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int AW    = 32,
   parameter int SEQ_W = 6
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     st_alloc_i,
   input  logic [SEQ_W-1:0]         st_alloc_seq_i,
   input  logic                     st_alloc_known_i,
   input  logic [AW-1:0]            st_alloc_addr_i,
   input  logic [1:0]               st_alloc_size_i,
   input  logic [31:0]              st_alloc_data_i,
   output logic [$clog2(DEPTH)-1:0] st_alloc_idx_o,
   output logic                     full_o,
   input  logic                     st_upd_i,
   input  logic [$clog2(DEPTH)-1:0] st_upd_idx_i,
   input  logic [AW-1:0]            st_upd_addr_i,
   input  logic                     ld_valid_i,
   input  logic [SEQ_W-1:0]         ld_seq_i,
   input  logic [AW-1:0]            ld_addr_i,
   input  logic [1:0]               ld_size_i,
   input  logic                     ld_signed_i,
   output logic                     ld_valid_o,
   output logic [31:0]              ld_data_o,
   output logic [3:0]               ld_hit_o,
   output logic                     ld_unknown_o,
   input  logic                     cm_i,
   output logic                     cm_rdy_o,
   output logic [AW-1:0]            cm_addr_o,
   output logic [1:0]               cm_size_o,
   output logic [31:0]              cm_data_o
);
   localparam int IDX_W = $clog2(DEPTH);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (SEQ_W < IDX_W + 2 || SEQ_W > 32) begin : g_bad_seq
      $error("SEQ_W must cover twice the queue span plus a wrap bit");
   end
   if (AW < 2 || AW > 64) begin : g_bad_aw
      $error("AW out of range");
   end

   logic [DEPTH-1:0]            vld_q, known_q;
   logic [DEPTH-1:0][AW-1:0]    addr_q;
   logic [DEPTH-1:0][1:0]       size_q;
   logic [DEPTH-1:0][31:0]      data_q;
   logic [DEPTH-1:0][SEQ_W-1:0] seq_q;

   logic [IDX_W-1:0] head, tail;
   logic             full, empty, push, pop;

   stq_ptrs #(.DEPTH(DEPTH)) u_ptrs (
      .clk(clk), .rst_n(rst_n), .push_i(push), .pop_i(pop),
      .head_o(head), .tail_o(tail), .full_o(full), .empty_o(empty)
   );

   assign push     = st_alloc_i && !full;
   assign cm_rdy_o = !empty && vld_q[head] && known_q[head];
   assign pop      = cm_i && cm_rdy_o;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q   <= '0;
         known_q <= '0;
         addr_q  <= '0;
         size_q  <= '0;
         data_q  <= '0;
         seq_q   <= '0;
      end else begin
         if (push) begin
            vld_q[tail]   <= 1'b1;
            known_q[tail] <= st_alloc_known_i;
            addr_q[tail]  <= st_alloc_addr_i;
            size_q[tail]  <= st_alloc_size_i;
            data_q[tail]  <= st_alloc_data_i;
            seq_q[tail]   <= st_alloc_seq_i;
         end
         if (st_upd_i && vld_q[st_upd_idx_i]) begin
            known_q[st_upd_idx_i] <= 1'b1;
            addr_q[st_upd_idx_i]  <= st_upd_addr_i;
         end
         if (pop) vld_q[head] <= 1'b0;
      end
   end

   // per-byte associative search
   logic [LANES-1:0][7:0] lane_byte;
   logic [LANES-1:0]      lane_hit;

   for (genvar b = 0; b < LANES; b++) begin : g_lane
      stq_lane #(.DEPTH(DEPTH), .AW(AW), .SEQ_W(SEQ_W), .LANE(b)) u_lane (
         .head_i(head), .vld_i(vld_q), .known_i(known_q), .addr_i(addr_q),
         .size_i(size_q), .data_i(data_q), .seq_i(seq_q),
         .ld_addr_i(ld_addr_i), .ld_seq_i(ld_seq_i), .ld_size_i(ld_size_i),
         .hit_o(lane_hit[b]), .byte_o(lane_byte[b])
      );
   end

   logic [31:0] ext_data;
   stq_extend u_ext (
      .bytes_i(lane_byte), .hit_i(lane_hit), .size_i(ld_size_i),
      .sgn_i(ld_signed_i), .data_o(ext_data)
   );

   // any older store with an unresolved address
   logic unk;
   always_comb begin
      unk = 1'b0;
      for (int k = 0; k < DEPTH; k++) begin
         if (vld_q[k] && !known_q[k] &&
             seq_older(32'(seq_q[k]), 32'(ld_seq_i), SEQ_W)) unk = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ld_valid_o   <= 1'b0;
         ld_data_o    <= '0;
         ld_hit_o     <= '0;
         ld_unknown_o <= 1'b0;
      end else begin
         ld_valid_o   <= ld_valid_i;
         ld_data_o    <= ld_valid_i ? ext_data : '0;
         ld_hit_o     <= ld_valid_i ? lane_hit : '0;
         ld_unknown_o <= ld_valid_i && unk;
      end
   end

   assign st_alloc_idx_o = tail;
   assign full_o         = full;
   assign cm_addr_o      = addr_q[head];
   assign cm_size_o      = size_q[head];
   assign cm_data_o      = data_q[head];
endmodule

// File: rtl/store_fwd_queue_chk.sv
module store_fwd_queue_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       st_alloc_i,
   input logic       st_upd_i,
   input logic       ld_valid_i,
   input logic [1:0] ld_size_i,
   input logic       ld_valid_o,
   input logic [3:0] ld_hit_o,
   input logic       full_o,
   input logic       cm_i,
   input logic       cm_rdy_o
);
   assert_ld_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ld_valid_i |=> ld_valid_o);

   assert_ld_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_valid_i |=> (!ld_valid_o && ld_hit_o == 4'b0000));

   assert_hit_byte_size_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_valid_i && ld_size_i == 2'd0) |=> (ld_hit_o[3:1] == 3'b000));

   assert_hit_half_size_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_valid_i && ld_size_i == 2'd1) |=> (ld_hit_o[3:2] == 2'b00));

   assert_full_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (full_o && !cm_i) |=> full_o);

   assert_commit_frees_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cm_i && cm_rdy_o && !st_alloc_i) |=> !full_o);

   assert_no_spurious_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!cm_rdy_o && !st_alloc_i && !st_upd_i) |=> !cm_rdy_o);
endmodule

bind store_fwd_queue store_fwd_queue_chk u_chk (
   .clk(clk), .rst_n(rst_n), .st_alloc_i(st_alloc_i), .st_upd_i(st_upd_i),
   .ld_valid_i(ld_valid_i), .ld_size_i(ld_size_i), .ld_valid_o(ld_valid_o),
   .ld_hit_o(ld_hit_o), .full_o(full_o), .cm_i(cm_i), .cm_rdy_o(cm_rdy_o)
);

// File: tb/store_fwd_queue_test.sv
module store_fwd_queue_test;
   localparam int DEPTH = 16;
   localparam int AW    = 32;
   localparam int SEQ_W = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        st_alloc_i = 1'b0;
   logic [5:0]  st_alloc_seq_i = '0;
   logic        st_alloc_known_i = 1'b0;
   logic [31:0] st_alloc_addr_i = '0;
   logic [1:0]  st_alloc_size_i = '0;
   logic [31:0] st_alloc_data_i = '0;
   logic [3:0]  st_alloc_idx_o;
   logic        full_o;
   logic        st_upd_i = 1'b0;
   logic [3:0]  st_upd_idx_i = '0;
   logic [31:0] st_upd_addr_i = '0;
   logic        ld_valid_i = 1'b0;
   logic [5:0]  ld_seq_i = '0;
   logic [31:0] ld_addr_i = '0;
   logic [1:0]  ld_size_i = '0;
   logic        ld_signed_i = 1'b0;
   logic        ld_valid_o;
   logic [31:0] ld_data_o;
   logic [3:0]  ld_hit_o;
   logic        ld_unknown_o;
   logic        cm_i = 1'b0;
   logic        cm_rdy_o;
   logic [31:0] cm_addr_o;
   logic [1:0]  cm_size_o;
   logic [31:0] cm_data_o;

   always #2 clk = ~clk;

   store_fwd_queue #(.DEPTH(DEPTH), .AW(AW), .SEQ_W(SEQ_W)) uut (.*);

   int  total = 0;
   int  fails = 0;
   bit  done  = 1'b0;

   task automatic chk(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic alloc(input logic [5:0] seq, input logic known, input logic [31:0] addr,
                        input logic [1:0] size, input logic [31:0] data);
      st_alloc_i = 1'b1; st_alloc_seq_i = seq; st_alloc_known_i = known;
      st_alloc_addr_i = addr; st_alloc_size_i = size; st_alloc_data_i = data;
      @(negedge clk);
      st_alloc_i = 1'b0;
   endtask

   task automatic load(input logic [5:0] seq, input logic [31:0] addr, input logic [1:0] size,
                       input logic sgn);
      ld_valid_i = 1'b1; ld_seq_i = seq; ld_addr_i = addr; ld_size_i = size; ld_signed_i = sgn;
      @(negedge clk);
      ld_valid_i = 1'b0;
   endtask

   task automatic commit();
      cm_i = 1'b1;
      @(negedge clk);
      cm_i = 1'b0;
   endtask

   task automatic upd(input logic [3:0] idx, input logic [31:0] addr);
      st_upd_i = 1'b1; st_upd_idx_i = idx; st_upd_addr_i = addr;
      @(negedge clk);
      st_upd_i = 1'b0;
   endtask

   typedef struct packed {
      logic [5:0]  seq;
      logic [31:0] addr;
      logic [1:0]  size;
      logic        sgn;
      logic [31:0] data;
      logic [3:0]  hit;
      logic        unk;
      logic [3:0]  req;
   } vec_t;

   // loads against the stores placed below; last field is the requirement number
   localparam vec_t VECS [10] = '{
      '{6'd7,  32'h10, 2'd1, 1'b0, 32'h0000_8405, 4'b0011, 1'b0, 4'd6},  // R6 bytes from two stores
      '{6'd7,  32'h10, 2'd1, 1'b1, 32'hFFFF_8405, 4'b0011, 1'b0, 4'd9},  // R9 sign fill
      '{6'd9,  32'h11, 2'd2, 1'b0, 32'h0007_0684, 4'b0111, 1'b0, 4'd8},  // R8 top byte uncovered
      '{6'd7,  32'h11, 2'd1, 1'b1, 32'h0000_0084, 4'b0001, 1'b0, 4'd9},  // R9 top byte missing, no fill
      '{6'd5,  32'h25, 2'd2, 1'b0, 32'h000A_0B0C, 4'b0111, 1'b0, 4'd7},  // R7 younger overlap ignored
      '{6'd11, 32'h26, 2'd1, 1'b1, 32'hFFFF_F1E0, 4'b0011, 1'b0, 4'd6},  // R6 youngest older wins
      '{6'd13, 32'h10, 2'd0, 1'b0, 32'h0000_0005, 4'b0001, 1'b1, 4'd10}, // R10 unknown older store
      '{6'd3,  32'h11, 2'd0, 1'b0, 32'h0000_0000, 4'b0000, 1'b0, 4'd8},  // R8 nothing covers
      '{6'd15, 32'h11, 2'd0, 1'b1, 32'h0000_0055, 4'b0001, 1'b1, 4'd6},  // R6 newest store
      '{6'd13, 32'h11, 2'd0, 1'b1, 32'hFFFF_FF84, 4'b0001, 1'b1, 4'd10}  // R10 still forwards
   };

   task automatic summary();
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         total++; fails++;
         $display("FAIL watchdog: actual hung expected finished");
         summary();
      end
   end

   initial begin
      logic [31:0] first_addr;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk(1, "full after reset", 32'(full_o), 32'd0);
      chk(1, "commit ready after reset", 32'(cm_rdy_o), 32'd0);
      chk(1, "alloc idx after reset", 32'(st_alloc_idx_o), 32'd0);
      chk(1, "load outputs after reset", {ld_data_o[27:0], ld_hit_o}, 32'd0);
      chk(1, "load valid/unknown after reset", {30'd0, ld_valid_o, ld_unknown_o}, 32'd0);

      // stores; R4 little-endian, unaligned, sizes 1/2/4
      alloc(6'd2,  1'b1, 32'h10, 2'd0, 32'h0000_0005);
      alloc(6'd4,  1'b1, 32'h24, 2'd2, 32'h0A0B_0C0D);
      alloc(6'd6,  1'b1, 32'h11, 2'd0, 32'h0000_0084);
      alloc(6'd8,  1'b1, 32'h12, 2'd1, 32'h0000_0706);
      alloc(6'd10, 1'b1, 32'h26, 2'd1, 32'h0000_F1E0);
      chk(2, "alloc index of sixth store", 32'(st_alloc_idx_o), 32'd5); // R2
      alloc(6'd12, 1'b0, 32'h0,  2'd2, 32'h0000_0099);
      alloc(6'd14, 1'b1, 32'h11, 2'd0, 32'h0000_0055);

      for (int i = 0; i < 10; i++) begin
         load(VECS[i].seq, VECS[i].addr, VECS[i].size, VECS[i].sgn);
         chk(int'(VECS[i].req), $sformatf("vec %0d data", i), ld_data_o, VECS[i].data);
         chk(int'(VECS[i].req), $sformatf("vec %0d hit", i), 32'(ld_hit_o), 32'(VECS[i].hit));
         chk(int'(VECS[i].req), $sformatf("vec %0d unknown", i), 32'(ld_unknown_o), 32'(VECS[i].unk));
      end

      // R11 resolve the unknown store; R4 size code 3 is four bytes
      upd(4'd5, 32'h10);
      load(6'd13, 32'h10, 2'd3, 1'b0);
      chk(11, "resolved store data", ld_data_o, 32'h0000_0099);
      chk(11, "resolved store hit", 32'(ld_hit_o), 32'hF);
      chk(10, "unknown cleared", 32'(ld_unknown_o), 32'd0); // R10

      // R3 head shown and retired in order
      chk(3, "head ready", 32'(cm_rdy_o), 32'd1);
      chk(3, "head addr", cm_addr_o, 32'h10);
      chk(3, "head data", cm_data_o, 32'h5);
      commit();
      chk(3, "second head addr", cm_addr_o, 32'h24);
      chk(3, "second head size", 32'(cm_size_o), 32'd2);
      for (int i = 0; i < 6; i++) commit();
      chk(3, "ready when empty", 32'(cm_rdy_o), 32'd0);

      // R3 unresolved head refuses commit
      alloc(6'd20, 1'b0, 32'h0, 2'd0, 32'h77);
      chk(3, "unresolved head not ready", 32'(cm_rdy_o), 32'd0);
      commit();
      upd(4'd7, 32'h200);
      chk(3, "refused commit left store in place", cm_addr_o, 32'h200);
      commit();
      chk(3, "queue empty again", 32'(cm_rdy_o), 32'd0);

      // R2 fill, overflow dropped, wrap of indices
      chk(2, "alloc idx after wrap start", 32'(st_alloc_idx_o), 32'd8);
      for (int i = 0; i < DEPTH; i++) alloc(6'(21 + i), 1'b1, 32'h300 + 32'(i), 2'd0, 32'(i));
      chk(2, "full after DEPTH stores", 32'(full_o), 32'd1);
      alloc(6'd40, 1'b1, 32'h3FF, 2'd0, 32'hEE);
      first_addr = cm_addr_o;
      chk(2, "oldest at head", first_addr, 32'h300);
      commit();
      chk(2, "not full after commit", 32'(full_o), 32'd0);
      for (int i = 1; i < DEPTH; i++) commit();
      chk(2, "overflow store was dropped", 32'(cm_rdy_o), 32'd0);

      // R7 age across tag wrap
      alloc(6'h3E, 1'b1, 32'h40, 2'd0, 32'h3C);
      load(6'h01, 32'h40, 2'd0, 1'b0);
      chk(7, "older across wrap data", ld_data_o, 32'h3C);
      chk(7, "older across wrap hit", 32'(ld_hit_o), 32'h1);
      load(6'h3D, 32'h40, 2'd0, 1'b0);
      chk(7, "younger store ignored", 32'(ld_hit_o), 32'h0);
      commit();

      // R5 same-edge allocation not visible; visible next cycle
      st_alloc_i = 1'b1; st_alloc_seq_i = 6'h02; st_alloc_known_i = 1'b1;
      st_alloc_addr_i = 32'h50; st_alloc_size_i = 2'd0; st_alloc_data_i = 32'h11;
      ld_valid_i = 1'b1; ld_seq_i = 6'h03; ld_addr_i = 32'h50; ld_size_i = 2'd0; ld_signed_i = 1'b0;
      @(negedge clk);
      st_alloc_i = 1'b0; ld_valid_i = 1'b0;
      chk(5, "load valid one cycle later", 32'(ld_valid_o), 32'd1);
      chk(5, "same-edge store unseen", 32'(ld_hit_o), 32'h0);
      load(6'h03, 32'h50, 2'd0, 1'b0);
      chk(5, "store seen next cycle", ld_data_o, 32'h11);
      @(negedge clk);
      chk(5, "valid drops when idle", 32'(ld_valid_o), 32'd0);

      done = 1'b1;
      summary();
   end
endmodule